// File: doc/BRIEF.md
# Register Window Controller

This block keeps track of a sliding view of 16 registers over a larger physical register file of `NAREG` entries. The file is divided into frames of four registers. The controller holds two pieces of state. The first is the current frame base, a frame index that wraps modulo `NAREG/4`. The second is a frame-start mask with one bit per frame, which marks the frames that begin a live call frame. It maps a visible register number to a physical index, and it carries out the window operations a processor pipeline issues to it: function entry, windowed return, explicit rotation, window check and stack-pointer move.

Each operation takes a single clock. On that edge the window state is updated and a trap code is registered. The trap code reports one of: illegal instruction, alloca, overflow or underflow. For overflow and underflow a size class of 4, 8 or 12 registers comes with it. When a window trap is raised, the previous frame base is latched into an old-base output and a one-cycle request to set the exception-mode bit is issued. The trap handlers and the register data path sit outside this block.

Top module: `wreg_window_ctrl`

## Requirements
- R1: Reset state. After reset the frame base is 0, the start mask holds only bit 0, `trap_o` is 0 (none), `trap_size_o` is 0, `owb_o` is 0 and `excm_set_o` is 0.
- R2: `phys_reg_o` always equals (base*4 + `vis_reg_i`) modulo `NAREG`, using the current registered base.
- R3: Entry (`op_i`=1), when legal, advances the base by `callinc_i` modulo NAREG/4. It then sets the start bit of the new base and leaves all other start bits unchanged.
- R4: Entry is illegal when `spec_i` > 3, or when the status is not exactly `woe_i`=1 with `excm_i`=0. In that case the next cycle shows `trap_o`=1 and the base and mask are unchanged.
- R5: Check (`op_i`=4) with width w=`amount_i[1:0]` looks for the smallest n in 1..w with the start bit at base+n set. If there is no such n, or the status is not `woe_i`=1 with `excm_i`=0, nothing changes and no trap is raised.
- R6: When the check finds n, with m = base+n: the base becomes m, `owb_o` takes the old base, `excm_set_o` pulses, and `trap_o`=3 (overflow). `trap_size_o` is 1 (4 regs) if bit m+1 is set, otherwise 2 (8 regs) if bit m+2 is set, otherwise 3 (12 regs).
- R7: Return (`op_i`=2) uses n = `ra_i[31:30]`. It is illegal (`trap_o`=1, state unchanged) when n = 0, when the status is wrong, or when the nearest set start bit among base-1, base-2 and base-3 exists at a distance other than n.
- R8: On a legal return, if the start bit at base-n is set, the base becomes base-n, the start bit of the old base is cleared, and no trap is raised.
- R9: On a legal return where the start bit at base-n is clear, the base still becomes base-n and the mask is kept. `trap_o`=4 (underflow), `trap_size_o`=n, `owb_o` takes the old base and `excm_set_o` pulses.
- R10: `ret_pc_o` = {`pc_hi_i`, `ra_i[29:0]`}.
- R11: Rotate (`op_i`=3) adds the signed 4-bit `amount_i` to the base modulo NAREG/4. The mask is unchanged and no trap is raised.
- R12: Stack-pointer move (`op_i`=5) raises `trap_o`=2 (alloca) when the start bits at base-1, base-2 and base-3 are all clear. Otherwise it has no effect.
- R13: Trap outputs are registered and reflect only the operation of the previous edge. After opcode 0, 6 or 7 (no operation), `trap_o`, `trap_size_o` and `excm_set_o` are 0. `owb_o` changes only on overflow or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 none, 1 entry, 2 return, 3 rotate, 4 check, 5 stack move |
| callinc_i | input | 2 | Frame increment for entry |
| spec_i | input | 4 | Register specifier of the entry instruction |
| amount_i | input | 4 | Signed rotate amount, or check width in bits [1:0] |
| woe_i | input | 1 | Window-overflow-enable status bit |
| excm_i | input | 1 | Exception-mode status bit |
| ra_i | input | 32 | Return-address register value |
| pc_hi_i | input | 2 | Top two bits of the current PC |
| vis_reg_i | input | 4 | Visible register number to map |
| trap_o | output | 3 | Trap code of the previous operation |
| trap_size_o | output | 2 | Window trap size class (1/2/3 = 4/8/12) |
| owb_o | output | FW | Saved old frame base |
| excm_set_o | output | 1 | Request to set exception mode |
| wbase_o | output | FW | Current frame base |
| wstart_o | output | NAREG/4 | Frame-start mask |
| ret_pc_o | output | 32 | Return target PC |
| phys_reg_o | output | log2(NAREG) | Physical index of `vis_reg_i` |

## Verification
The bench aims at wraparound. Probes such as base+5 and base-3 must roll past the ends of the mask. A design that lost the wrap would pick the wrong overflow size, or call a frame empty when it is not. The bench also targets return decisions where the nearest lower frame sits at a distance other than n. Here a faulty controller would rotate when it should fault, or clear the wrong start bit. Check widths that stop just short of a set frame are tested as well: checking one frame too far would raise a spurious overflow. A long random mix of operations with biased status bits walks the mask through dense and sparse patterns.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ENTRY = 3'd1,
    OP_RETW  = 3'd2,
    OP_ROTW  = 3'd3,
    OP_CHECK = 3'd4,
    OP_MOVSP = 3'd5
  } wop_e;

  typedef enum logic [2:0] {
    TR_NONE      = 3'd0,
    TR_ILLEGAL   = 3'd1,
    TR_ALLOCA    = 3'd2,
    TR_OVERFLOW  = 3'd3,
    TR_UNDERFLOW = 3'd4
  } wtrap_e;

  localparam int unsigned PROBE_LO = 3;  // frames probed below base
  localparam int unsigned PROBE_HI = 5;  // frames probed above base
endpackage

// File: rtl/wreg_probe.sv
module wreg_probe
  import wreg_pkg::*;
#(
  parameter int unsigned NF = 16,
  localparam int unsigned FW = $clog2(NF),
  localparam int unsigned NP = PROBE_LO + PROBE_HI + 1
) (
  input  logic [FW-1:0] base_i,
  input  logic [NF-1:0] start_i,
  output logic [NP-1:0] near_o   // near_o[k] = start at base + k - PROBE_LO
);
  for (genvar k = 0; k < NP; k++) begin : g_tap
    localparam logic [FW-1:0] OFF = FW'(k + NF - PROBE_LO);
    logic [FW-1:0] idx;
    assign idx       = base_i + OFF;
    assign near_o[k] = start_i[idx];
  end
endmodule

// File: rtl/wreg_exec.sv
module wreg_exec
  import wreg_pkg::*;
#(
  parameter int unsigned NF = 16,
  localparam int unsigned FW = $clog2(NF),
  localparam int unsigned NP = PROBE_LO + PROBE_HI + 1
) (
  input  logic [2:0]    op_i,
  input  logic [1:0]    callinc_i,
  input  logic [3:0]    spec_i,
  input  logic [3:0]    amount_i,
  input  logic          woe_i,
  input  logic          excm_i,
  input  logic [1:0]    ra_top_i,
  input  logic [FW-1:0] base_i,
  input  logic [NF-1:0] start_i,
  input  logic [NP-1:0] near_i,
  output logic [FW-1:0] base_o,
  output logic [NF-1:0] start_o,
  output logic [2:0]    trap_o,
  output logic [1:0]    size_o,
  output logic          save_o
);
  logic          ok;
  logic [1:0]    fnd, below;
  logic [FW-1:0] ent, dest;

  always_comb begin
    ok      = woe_i & ~excm_i;
    base_o  = base_i;
    start_o = start_i;
    trap_o  = TR_NONE;
    size_o  = 2'd0;
    save_o  = 1'b0;
    fnd     = 2'd0;
    below   = 2'd0;
    // descending loops so the nearest frame wins
    for (int j = 3; j >= 1; j--) begin
      if (j <= int'(amount_i[1:0]) && near_i[PROBE_LO + j]) fnd = 2'(j);
      if (near_i[PROBE_LO - j]) below = 2'(j);
    end
    ent  = base_i + FW'(callinc_i);
    dest = base_i - FW'(ra_top_i);

    case (op_i)
      OP_ENTRY: begin
        if (spec_i > 4'd3 || !ok) trap_o = TR_ILLEGAL;
        else begin
          base_o  = ent;
          start_o = start_i | (NF'(1) << ent);
        end
      end
      OP_RETW: begin
        if (ra_top_i == 2'd0 || (below != 2'd0 && below != ra_top_i) || !ok)
          trap_o = TR_ILLEGAL;
        else begin
          base_o = dest;
          if (near_i[PROBE_LO - int'(ra_top_i)]) start_o = start_i & ~(NF'(1) << base_i);
          else begin
            trap_o = TR_UNDERFLOW;
            size_o = ra_top_i;
            save_o = 1'b1;
          end
        end
      end
      OP_ROTW: base_o = base_i + FW'($signed(amount_i));
      OP_CHECK: begin
        if (ok && fnd != 2'd0) begin
          base_o = base_i + FW'(fnd);
          trap_o = TR_OVERFLOW;
          save_o = 1'b1;
          if (near_i[PROBE_LO + int'(fnd) + 1])      size_o = 2'd1;
          else if (near_i[PROBE_LO + int'(fnd) + 2]) size_o = 2'd2;
          else                                       size_o = 2'd3;
        end
      end
      OP_MOVSP: if (near_i[PROBE_LO-1:0] == '0) trap_o = TR_ALLOCA;
      default: ;
    endcase
  end
endmodule

// File: rtl/wreg_window_ctrl.sv
module wreg_window_ctrl
  import wreg_pkg::*;
#(
  parameter int unsigned NAREG = 64,
  localparam int unsigned NF = NAREG / 4,
  localparam int unsigned FW = $clog2(NF),
  localparam int unsigned PW = $clog2(NAREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [1:0]    callinc_i,
  input  logic [3:0]    spec_i,
  input  logic [3:0]    amount_i,
  input  logic          woe_i,
  input  logic          excm_i,
  input  logic [31:0]   ra_i,
  input  logic [1:0]    pc_hi_i,
  input  logic [3:0]    vis_reg_i,
  output logic [2:0]    trap_o,
  output logic [1:0]    trap_size_o,
  output logic [FW-1:0] owb_o,
  output logic          excm_set_o,
  output logic [FW-1:0] wbase_o,
  output logic [NF-1:0] wstart_o,
  output logic [31:0]   ret_pc_o,
  output logic [PW-1:0] phys_reg_o
);
  localparam int unsigned NP = PROBE_LO + PROBE_HI + 1;

  logic [NP-1:0] near;
  logic [FW-1:0] base_q, base_d;
  logic [NF-1:0] start_q, start_d;
  logic [2:0]    trap_d;
  logic [1:0]    size_d;
  logic          save_d;
  logic          past_ok;

  wreg_probe #(.NF(NF)) u_probe (
    .base_i (base_q),
    .start_i(start_q),
    .near_o (near)
  );

  wreg_exec #(.NF(NF)) u_exec (
    .op_i     (op_i),
    .callinc_i(callinc_i),
    .spec_i   (spec_i),
    .amount_i (amount_i),
    .woe_i    (woe_i),
    .excm_i   (excm_i),
    .ra_top_i (ra_i[31:30]),
    .base_i   (base_q),
    .start_i  (start_q),
    .near_i   (near),
    .base_o   (base_d),
    .start_o  (start_d),
    .trap_o   (trap_d),
    .size_o   (size_d),
    .save_o   (save_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q      <= '0;
      start_q     <= NF'(1);
      trap_o      <= TR_NONE;
      trap_size_o <= 2'd0;
      owb_o       <= '0;
      excm_set_o  <= 1'b0;
      past_ok     <= 1'b0;
    end else begin
      base_q      <= base_d;
      start_q     <= start_d;
      trap_o      <= trap_d;
      trap_size_o <= size_d;
      excm_set_o  <= save_d;
      past_ok     <= 1'b1;
      if (save_d) owb_o <= base_q;
    end
  end

  assign wbase_o    = base_q;
  assign wstart_o   = start_q;
  assign ret_pc_o   = {pc_hi_i, ra_i[29:0]};
  assign phys_reg_o = {base_q, 2'b00} + PW'(vis_reg_i);

  // R8: a return never empties the mask
  assert_mask_live_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wstart_o != '0);

  // R6: overflow lands on the live frame it found
  assert_ovf_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o == TR_OVERFLOW |-> wstart_o[wbase_o] && excm_set_o && trap_size_o != 2'd0);

  // R9: underflow rewinds by its size onto an empty frame
  assert_unf_rewind_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o == TR_UNDERFLOW |-> wbase_o == owb_o - FW'(trap_size_o) && !wstart_o[wbase_o]);

  // R4: illegal operations leave the window alone
  assert_illegal_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && trap_o == TR_ILLEGAL |-> $stable(wbase_o) && $stable(wstart_o));

  // R13: no trap after an idle cycle
  assert_idle_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(op_i) == OP_NOP |-> trap_o == TR_NONE && !excm_set_o);
endmodule

// File: tb/sim_wreg_window_ctrl.sv
module sim_wreg_window_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NAREG = 64;
  localparam int NF = NAREG / 4;
  localparam int FW = $clog2(NF);
  localparam int PW = $clog2(NAREG);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op = '0;
  logic [1:0]    callinc = '0;
  logic [3:0]    spec = '0, amount = '0, vis = '0;
  logic          woe = 1'b0, excm = 1'b0;
  logic [31:0]   ra = '0;
  logic [1:0]    pc_hi = '0;
  logic [2:0]    trap;
  logic [1:0]    tsize;
  logic [FW-1:0] owb, wbase;
  logic          exset;
  logic [NF-1:0] wstart;
  logic [31:0]   ret_pc;
  logic [PW-1:0] phys;

  int nvec = 0, nfail = 0;
  int mb = 0, mowb = 0;
  bit [NF-1:0] ms = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  wreg_window_ctrl #(.NAREG(NAREG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .callinc_i(callinc), .spec_i(spec),
    .amount_i(amount), .woe_i(woe), .excm_i(excm), .ra_i(ra), .pc_hi_i(pc_hi),
    .vis_reg_i(vis), .trap_o(trap), .trap_size_o(tsize), .owb_o(owb),
    .excm_set_o(exset), .wbase_o(wbase), .wstart_o(wstart), .ret_pc_o(ret_pc),
    .phys_reg_o(phys)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit sb(int k);
    return ms[((mb + k) % NF + NF) % NF];
  endfunction

  task automatic do_op(int o, int ci, int sp, int am, bit w, bit x, logic [31:0] r,
                       int ph, int vr, string tag);
    int et = 0, es = 0, nb = mb, n, m, a;
    bit ee = 0, ok = w && !x;
    bit [NF-1:0] ns = ms;
    case (o)
      1: if (sp > 3 || !ok) et = 1;
         else begin nb = (mb + ci) % NF; ns[nb] = 1'b1; end
      2: begin
        n = int'(r[31:30]); m = 0;
        for (int k = 1; k <= 3; k++) if (m == 0 && sb(-k)) m = k;
        if (n == 0 || (m != 0 && m != n) || !ok) et = 1;
        else begin
          nb = (mb - n + NF) % NF;
          if (ms[nb]) ns[mb] = 1'b0;
          else begin et = 4; es = n; ee = 1; mowb = mb; end
        end
      end
      3: begin a = (am >= 8) ? am - 16 : am; nb = ((mb + a) % NF + NF) % NF; end
      4: if (ok) begin
        m = 0;
        for (int k = 1; k <= (am & 3); k++) if (m == 0 && sb(k)) m = k;
        if (m != 0) begin
          nb = (mb + m) % NF; et = 3; ee = 1; mowb = mb;
          es = sb(m + 1) ? 1 : (sb(m + 2) ? 2 : 3);
        end
      end
      5: if (!sb(-1) && !sb(-2) && !sb(-3)) et = 2;
      default: ;
    endcase
    op = 3'(o); callinc = 2'(ci); spec = 4'(sp); amount = 4'(am);
    woe = w; excm = x; ra = r; pc_hi = 2'(ph); vis = 4'(vr);
    @(posedge clk); #1;
    mb = nb; ms = ns;
    chk(tag, "trap", trap, et);
    chk(tag, "size", tsize, es);
    chk(tag, "excm_set", exset, ee);
    chk(tag, "owb", owb, mowb);
    chk(tag, "base", wbase, mb);
    chk(tag, "start", wstart, ms);
    chk("R10", "ret_pc", ret_pc, {2'(ph), r[29:0]});
    chk("R2", "phys", phys, (mb * 4 + vr) % NAREG);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD + 2);
    chk("R1", "base", wbase, 0);
    chk("R1", "start", wstart, 1);
    chk("R1", "trap", trap, 0);
    chk("R1", "owb", owb, 0);
    #(CLK_PERIOD);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R3 entry with increments 1,2,3
    do_op(1, 1, 2, 0, 1, 0, 0, 1, 5, "R3");
    do_op(1, 2, 3, 0, 1, 0, 0, 2, 15, "R3");
    do_op(1, 3, 0, 0, 1, 0, 0, 3, 7, "R3");
    // R4 illegal entries
    do_op(1, 1, 4, 0, 1, 0, 0, 0, 1, "R4");
    do_op(1, 1, 1, 0, 1, 1, 0, 0, 1, "R4");
    do_op(1, 1, 1, 0, 0, 0, 0, 0, 1, "R4");
    // R13 idle after trap
    do_op(0, 0, 0, 0, 1, 0, 0, 0, 0, "R13");
    do_op(7, 0, 0, 0, 1, 0, 0, 0, 0, "R13");
    // R5 check nothing ahead / bad status; base is 6 with mask {0,1,3,6}
    do_op(4, 0, 0, 3, 1, 0, 0, 0, 0, "R5");
    do_op(3, 0, 0, 15, 1, 0, 0, 0, 0, "R11");  // base 5
    do_op(4, 0, 0, 1, 0, 0, 0, 0, 0, "R5");
    do_op(4, 0, 0, 0, 1, 0, 0, 0, 0, "R5");
    // R6 overflow sizes: mask {0,1,3,6}
    do_op(3, 0, 0, 10, 1, 0, 0, 0, 0, "R11");  // base 15
    do_op(4, 0, 0, 1, 1, 0, 0, 0, 0, "R6");    // m=0, bit1 -> 4
    do_op(4, 0, 0, 1, 1, 0, 0, 0, 0, "R6");    // m=1, bit3 -> 8
    do_op(3, 0, 0, 1, 1, 0, 0, 0, 0, "R11");   // base 2
    do_op(4, 0, 0, 3, 1, 0, 0, 0, 0, "R6");    // m=3 -> 12
    // R12 stack move
    do_op(5, 0, 0, 0, 1, 0, 0, 0, 0, "R12");
    do_op(3, 0, 0, 5, 1, 0, 0, 0, 0, "R11");   // base 8
    do_op(5, 0, 0, 0, 1, 0, 0, 0, 0, "R12");
    // R7 illegal returns
    do_op(2, 0, 0, 0, 1, 0, 32'h0000_1234, 1, 0, "R7");
    do_op(2, 0, 0, 0, 1, 1, 32'h4000_1234, 1, 0, "R7");
    do_op(2, 0, 0, 0, 1, 0, 32'h8000_0010, 2, 0, "R7");  // nearest at 2, n=2 ok
    do_op(3, 0, 0, 1, 1, 0, 0, 0, 0, "R11");
    do_op(2, 0, 0, 0, 1, 0, 32'h4000_0010, 2, 0, "R7");
    // R9 underflow on empty region
    do_op(3, 0, 0, 6, 1, 0, 0, 0, 0, "R11");
    do_op(2, 0, 0, 0, 1, 0, 32'hC0AB_CDEF, 3, 9, "R9");
    do_op(2, 0, 0, 0, 1, 0, 32'h4000_0000, 0, 9, "R9");
    // R8 entry then matched return
    do_op(1, 1, 1, 0, 1, 0, 0, 0, 0, "R3");
    do_op(2, 0, 0, 0, 1, 0, 32'h4000_0100, 1, 3, "R8");
    // random mix
    for (int i = 0; i < 6000; i++) begin
      int o = int'($urandom_range(0, 7));
      bit w = ($urandom_range(0, 9) != 0);
      bit x = ($urandom_range(0, 9) == 0);
      string t;
      case (o)
        1: t = "R3"; 2: t = "R8"; 3: t = "R11"; 4: t = "R6"; 5: t = "R12";
        default: t = "R13";
      endcase
      do_op(o, int'($urandom_range(0, 3)), int'($urandom_range(0, 4)),
            int'($urandom_range(0, 15)), w, x, $urandom, int'($urandom_range(0, 3)),
            int'($urandom_range(0, 15)), t);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule